// File: doc/BRIEF.md
# SERDES Lane Override and Hard-Reset Retry Sequencer

This block drives the per-lane register sequence that a SATA port needs around a link hard reset on a shared SERDES. It does not touch the PHY directly. It issues logical register reads and writes, one at a time, through a request/response port of the kind an indirect SERDES access engine provides. Each lane's registers sit at a fixed base plus the lane number times 0x100.

Three one-cycle commands start the work. The override command first waits for the receive side to leave half-rate mode. It then forces the receive path into DPLL mode 3, pulses the DPLL reset and waits a settle interval. Last, it forces the transmit path and ORs in the attenuation value. The release command drops the receive force bit. The hard-reset command loops over three steps: release, request a link reset from the neighbouring logic, then override. The loop repeats while the link stays offline and the device-detect field is nonzero, up to a parameterised retry limit.

When the lane has no PHY behind it, no register traffic is issued at all.

Top module: `lovr_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `req_valid` and `link_rst_req` are all 0.
- R2: Every register address is offset + lane*0x100. The offsets are 0x2001 for TX input status, 0x2002 for RX input status, 0x2004 for TX override and 0x2005 for RX override. The lane is the `lane_sel` value latched when the command is accepted.
- R3: An override starts by reading RX input status. The read repeats while bit 0 (half rate) is 1, up to POLL_LIMIT reads in total. If bit 0 is still 1 on the last allowed read, `timeout` is set and the sequence carries on.
- R4: Next comes one more RX status read, value B. Five writes to RX override follow, in this order:
  - B with bit 14 cleared;
  - with bit 14 set;
  - with bits 10:8 replaced by 3;
  - with bit 11 set;
  - with bit 11 cleared.
- R5: After the fifth RX override write, no further request is accepted for at least SETTLE_CYCLES cycles.
- R6: When `tx_atten[3]` is 0, a TX status read T is followed by three writes to TX override:
  - T with bit 15 cleared;
  - then with bit 15 set;
  - then ORed with `tx_atten[2:0]` shifted into bits 12:10.

  When `tx_atten[3]` is 1, the TX part issues no traffic at all.
- R7: A release command reads RX input status and writes that value, with bit 14 cleared, to RX override. It issues nothing else.
- R8: With `phy_en` low, override and release commands issue no request, and `done` is 1 in the cycle after the start pulse. A hard reset with `phy_en` low still requests link resets, with no register traffic.
- R9: Each hard-reset attempt runs in this order: release traffic, one `link_rst_req` pulse, wait for `link_rst_done`, then override traffic. `link_online` and `link_det` are sampled in the cycle `link_rst_done` is 1.
- R10: While the sampled link is offline and `link_det` is nonzero, the attempt repeats, up to RETRY_LIMIT+1 attempts in total. If the link is still offline after the last attempt, `timeout` is set.
- R11: A sampled `link_det` of 0 ends the hard reset after that attempt, without setting `timeout`.
- R12: While `req_valid` is 1 and `req_ready` is 0, the request fields hold. Only one request is outstanding at a time.
- R13: `done` is a one-cycle pulse at the end of each accepted command. Start pulses that arrive while `busy` is 1 are ignored. If start pulses coincide, the hard reset wins over the override, and the override wins over the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_en | input | 1 | Lane has a PHY behind it |
| lane_sel | input | LANE_W | Lane within the SERDES |
| tx_atten | input | 4 | TX attenuation; bit 3 set skips the TX part |
| ovr_start | input | 1 | Start the override sequence |
| dis_start | input | 1 | Start the release sequence |
| hrst_start | input | 1 | Start the hard-reset retry loop |
| link_rst_req | output | 1 | One-cycle request for a link hard reset |
| link_rst_done | input | 1 | Link reset finished; status inputs valid |
| link_online | input | 1 | Link came up |
| link_det | input | 2 | Device-detect status field |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Access engine accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Logical register address |
| req_wdata | output | DW | Write data |
| resp_valid | input | 1 | Read data valid |
| resp_rdata | input | DW | Read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (pulse) |
| timeout | output | 1 | Half-rate poll or retry limit gave up during the last command |

## Verification
The bound checker enforces these properties on every cycle:
- request fields stay stable under back-pressure;
- addresses decode to one of the four lane registers of the latched lane;
- `done` and `link_rst_req` are single-cycle pulses;
- an idle block is silent on both ports;
- the attempt count stays within its bound.

Only the bench scenarios can show the parts that depend on data and history. These include the exact order and values of the read-modify-write series, the half-rate poll limit and when it gives up, the settle gap, the skipped TX part, and how many link resets happen for each online and detect pattern.

// File: rtl/lovr_pkg.sv
package lovr_pkg;
  localparam int REG_AW = 16;
  localparam int REG_DW = 16;

  localparam logic [15:0] OFS_TX_STS = 16'h2001;
  localparam logic [15:0] OFS_RX_STS = 16'h2002;
  localparam logic [15:0] OFS_TX_OVR = 16'h2004;
  localparam logic [15:0] OFS_RX_OVR = 16'h2005;
  localparam int          LANE_SHIFT = 8;

  localparam int          B_HALF     = 0;
  localparam int          B_RX_FORCE = 14;
  localparam int          B_TX_FORCE = 15;
  localparam int          B_DPLL_RST = 11;
  localparam logic [2:0]  DPLL_SEL   = 3'd3;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_POLL, SQ_RXRD, SQ_RXWR, SQ_SETTLE,
    SQ_TXRD, SQ_TXWR, SQ_DISRD, SQ_DISWR, SQ_FIN
  } seq_st_e;

  typedef enum logic [2:0] {
    TP_IDLE, TP_SINGLE, TP_DIS, TP_LINK, TP_OVR, TP_EVAL
  } top_st_e;

  function automatic logic [15:0] lane_addr(input logic [15:0] ofs, input logic [7:0] lane);
    return ofs + (16'(lane) << LANE_SHIFT);
  endfunction

  // cumulative value of the k-th receive override write, from the status read
  function automatic logic [15:0] rx_step(input logic [15:0] base, input logic [2:0] k);
    logic [15:0] v;
    v = base;
    v[B_RX_FORCE] = (k != 3'd0);
    if (k >= 3'd2) v[10:8] = DPLL_SEL;
    if (k == 3'd3) v[B_DPLL_RST] = 1'b1;
    if (k == 3'd4) v[B_DPLL_RST] = 1'b0;
    return v;
  endfunction

  function automatic logic [15:0] tx_step(input logic [15:0] base, input logic [2:0] k,
                                          input logic [2:0] att);
    logic [15:0] v;
    v = base;
    v[B_TX_FORCE] = (k != 3'd0);
    if (k >= 3'd2) v[12:10] = v[12:10] | att;
    return v;
  endfunction

  function automatic logic [15:0] release_value(input logic [15:0] base);
    logic [15:0] v;
    v = base;
    v[B_RX_FORCE] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/lovr_bus_engine.sv
module lovr_bus_engine #(
  parameter int AW = lovr_pkg::REG_AW,
  parameter int DW = lovr_pkg::REG_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          resp_valid,
  input  logic [DW-1:0] resp_rdata
);
  typedef enum logic [1:0] {BE_IDLE, BE_REQ, BE_RSP} be_st_e;
  be_st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BE_IDLE;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      cmd_done  <= 1'b0;
      cmd_rdata <= '0;
    end else begin
      cmd_done <= 1'b0;
      unique case (st)
        BE_IDLE: if (cmd_go) begin
          req_valid <= 1'b1;
          req_write <= cmd_wr;
          req_addr  <= cmd_addr;
          req_wdata <= cmd_wdata;
          st        <= BE_REQ;
        end
        BE_REQ: if (req_ready) begin
          req_valid <= 1'b0;
          if (req_write) begin
            cmd_done <= 1'b1;
            st       <= BE_IDLE;
          end else begin
            st <= BE_RSP;
          end
        end
        BE_RSP: if (resp_valid) begin
          cmd_rdata <= resp_rdata;
          cmd_done  <= 1'b1;
          st        <= BE_IDLE;
        end
        default: st <= BE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lovr_settle_timer.sv
module lovr_settle_timer #(
  parameter int CYCLES = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'((CYCLES < 1) ? 1 : CYCLES);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (start) begin
        cnt    <= LOAD;
        active <= 1'b1;
      end else if (active) begin
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          fire   <= 1'b1;
        end
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/lovr_ovr_seq.sv
module lovr_ovr_seq #(
  parameter int LANE_W        = 2,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETTLE_CYCLES = 750000,
  parameter int AW            = lovr_pkg::REG_AW,
  parameter int DW            = lovr_pkg::REG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ovr,
  input  logic              go_rel,
  input  logic [LANE_W-1:0] lane_in,
  input  logic [3:0]        atten_in,
  output logic              cmd_go,
  output logic              cmd_wr,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_wdata,
  input  logic              cmd_done,
  input  logic [DW-1:0]     cmd_rdata,
  output logic              seq_done,
  output logic              poll_gaveup,
  output logic [LANE_W-1:0] lane_q
);
  import lovr_pkg::*;

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] PMAX = PW'(POLL_LIMIT);

  seq_st_e        st;
  logic           issued;
  logic [2:0]     step;
  logic [DW-1:0]  base;
  logic [PW-1:0]  polls;
  logic [3:0]     atten_q;
  logic           settle_go;
  logic           settle_fire;
  logic [7:0]     lane8;
  logic           is_access;
  logic [PW-1:0]  polls_nx;

  assign lane8    = 8'(lane_q);
  assign polls_nx = polls + PW'(1);

  lovr_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(settle_go), .fire(settle_fire)
  );

  always_comb begin
    is_access = 1'b1;
    cmd_wr    = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    unique case (st)
      SQ_POLL, SQ_RXRD, SQ_DISRD: cmd_addr = AW'(lane_addr(OFS_RX_STS, lane8));
      SQ_TXRD:                    cmd_addr = AW'(lane_addr(OFS_TX_STS, lane8));
      SQ_RXWR: begin
        cmd_wr    = 1'b1;
        cmd_addr  = AW'(lane_addr(OFS_RX_OVR, lane8));
        cmd_wdata = DW'(rx_step(16'(base), step));
      end
      SQ_TXWR: begin
        cmd_wr    = 1'b1;
        cmd_addr  = AW'(lane_addr(OFS_TX_OVR, lane8));
        cmd_wdata = DW'(tx_step(16'(base), step, atten_q[2:0]));
      end
      SQ_DISWR: begin
        cmd_wr    = 1'b1;
        cmd_addr  = AW'(lane_addr(OFS_RX_OVR, lane8));
        cmd_wdata = DW'(release_value(16'(base)));
      end
      default: is_access = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      issued      <= 1'b0;
      step        <= '0;
      base        <= '0;
      polls       <= '0;
      atten_q     <= '0;
      lane_q      <= '0;
      cmd_go      <= 1'b0;
      seq_done    <= 1'b0;
      poll_gaveup <= 1'b0;
      settle_go   <= 1'b0;
    end else begin
      cmd_go    <= 1'b0;
      seq_done  <= 1'b0;
      settle_go <= 1'b0;
      if (is_access && !issued) begin
        cmd_go <= 1'b1;
        issued <= 1'b1;
      end else if (is_access && cmd_done) begin
        issued <= 1'b0;
        unique case (st)
          SQ_POLL: begin
            polls <= polls_nx;
            if (!cmd_rdata[B_HALF] || polls_nx >= PMAX) begin
              poll_gaveup <= cmd_rdata[B_HALF];
              st          <= SQ_RXRD;
            end
          end
          SQ_RXRD: begin
            base <= cmd_rdata;
            step <= 3'd0;
            st   <= SQ_RXWR;
          end
          SQ_RXWR: begin
            if (step == 3'd4) begin
              settle_go <= 1'b1;
              st        <= SQ_SETTLE;
            end else begin
              step <= step + 3'd1;
            end
          end
          SQ_TXRD: begin
            base <= cmd_rdata;
            step <= 3'd0;
            st   <= SQ_TXWR;
          end
          SQ_TXWR: begin
            if (step == 3'd2) st <= SQ_FIN;
            else              step <= step + 3'd1;
          end
          SQ_DISRD: begin
            base <= cmd_rdata;
            st   <= SQ_DISWR;
          end
          SQ_DISWR: st <= SQ_FIN;
          default:  st <= SQ_IDLE;
        endcase
      end else begin
        unique case (st)
          SQ_IDLE: begin
            if (go_ovr) begin
              lane_q      <= lane_in;
              atten_q     <= atten_in;
              polls       <= '0;
              poll_gaveup <= 1'b0;
              st          <= SQ_POLL;
            end else if (go_rel) begin
              lane_q      <= lane_in;
              poll_gaveup <= 1'b0;
              st          <= SQ_DISRD;
            end
          end
          SQ_SETTLE: if (settle_fire) st <= atten_q[3] ? SQ_FIN : SQ_TXRD;
          SQ_FIN: begin
            seq_done <= 1'b1;
            st       <= SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lovr_sequencer.sv
module lovr_sequencer #(
  parameter int LANE_W        = 2,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETTLE_CYCLES = 750000,
  parameter int RETRY_LIMIT   = 100,
  parameter int AW            = lovr_pkg::REG_AW,
  parameter int DW            = lovr_pkg::REG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_en,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic [3:0]        tx_atten,
  input  logic              ovr_start,
  input  logic              dis_start,
  input  logic              hrst_start,
  output logic              link_rst_req,
  input  logic              link_rst_done,
  input  logic              link_online,
  input  logic [1:0]        link_det,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [DW-1:0]     req_wdata,
  input  logic              resp_valid,
  input  logic [DW-1:0]     resp_rdata,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  import lovr_pkg::*;

  localparam int ATT_W = $clog2(RETRY_LIMIT + 2);
  localparam logic [ATT_W-1:0] ATT_RETRY_MAX = ATT_W'(RETRY_LIMIT);

  top_st_e           st;
  logic              en_q;
  logic              online_q;
  logic [1:0]        det_q;
  logic [ATT_W-1:0]  attempt_cnt;
  logic              go_ovr, go_rel;
  logic              cmd_go, cmd_wr, cmd_done;
  logic [AW-1:0]     cmd_addr;
  logic [DW-1:0]     cmd_wdata, cmd_rdata;
  logic              seq_done, poll_gaveup;
  logic [LANE_W-1:0] lane_active;
  logic              link_gave_up;
  logic              retry_ok;

  assign retry_ok     = (attempt_cnt <= ATT_RETRY_MAX);
  assign link_gave_up = !online_q && (det_q != 2'b00) && !retry_ok;

  lovr_bus_engine #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata)
  );

  lovr_ovr_seq #(
    .LANE_W(LANE_W), .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYCLES(SETTLE_CYCLES), .AW(AW), .DW(DW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_ovr(go_ovr), .go_rel(go_rel), .lane_in(lane_sel), .atten_in(tx_atten),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .seq_done(seq_done), .poll_gaveup(poll_gaveup), .lane_q(lane_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= TP_IDLE;
      en_q         <= 1'b0;
      online_q     <= 1'b0;
      det_q        <= '0;
      attempt_cnt  <= '0;
      go_ovr       <= 1'b0;
      go_rel       <= 1'b0;
      link_rst_req <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      timeout      <= 1'b0;
    end else begin
      go_ovr       <= 1'b0;
      go_rel       <= 1'b0;
      link_rst_req <= 1'b0;
      done         <= 1'b0;
      unique case (st)
        TP_IDLE: begin
          if (hrst_start) begin
            en_q        <= phy_en;
            timeout     <= 1'b0;
            busy        <= 1'b1;
            attempt_cnt <= ATT_W'(1);
            if (phy_en) begin
              go_rel <= 1'b1;
              st     <= TP_DIS;
            end else begin
              link_rst_req <= 1'b1;
              st           <= TP_LINK;
            end
          end else if (ovr_start || dis_start) begin
            timeout <= 1'b0;
            if (!phy_en) begin
              done <= 1'b1;
            end else begin
              go_ovr <= ovr_start;
              go_rel <= !ovr_start;
              busy   <= 1'b1;
              st     <= TP_SINGLE;
            end
          end
        end
        TP_SINGLE: if (seq_done) begin
          timeout <= poll_gaveup;
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= TP_IDLE;
        end
        TP_DIS: if (seq_done) begin
          link_rst_req <= 1'b1;
          st           <= TP_LINK;
        end
        TP_LINK: if (link_rst_done) begin
          online_q <= link_online;
          det_q    <= link_det;
          if (en_q) begin
            go_ovr <= 1'b1;
            st     <= TP_OVR;
          end else begin
            st <= TP_EVAL;
          end
        end
        TP_OVR: if (seq_done) begin
          if (poll_gaveup) timeout <= 1'b1;
          st <= TP_EVAL;
        end
        TP_EVAL: begin
          if (online_q || det_q == 2'b00 || !retry_ok) begin
            if (link_gave_up) timeout <= 1'b1;
            done <= 1'b1;
            busy <= 1'b0;
            st   <= TP_IDLE;
          end else begin
            attempt_cnt <= attempt_cnt + ATT_W'(1);
            if (en_q) begin
              go_rel <= 1'b1;
              st     <= TP_DIS;
            end else begin
              link_rst_req <= 1'b1;
              st           <= TP_LINK;
            end
          end
        end
        default: st <= TP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lovr_checker.sv
module lovr_checker #(
  parameter int LANE_W      = 2,
  parameter int RETRY_LIMIT = 100,
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int ATT_W       = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [DW-1:0]     req_wdata,
  input logic              busy,
  input logic              done,
  input logic              link_rst_req,
  input logic [LANE_W-1:0] lane_active,
  input logic [ATT_W-1:0]  attempt_cnt
);
  logic [7:0] lo_byte;
  logic [7:0] hi_byte;
  assign lo_byte = req_addr[7:0];
  assign hi_byte = req_addr[15:8];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)) // R12
    else $error("request changed under back-pressure");

  AST_ADDR_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (hi_byte == 8'h20 + 8'(lane_active)) &&
                  (lo_byte == 8'h01 || lo_byte == 8'h02 || lo_byte == 8'h04 || lo_byte == 8'h05)) // R2
    else $error("address outside lane register set");

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> (lo_byte == 8'h04 || lo_byte == 8'h05)) // R4
    else $error("write to a status register");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) // R13
    else $error("done longer than one cycle");

  AST_LRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst_req |=> !link_rst_req) // R9
    else $error("link reset request longer than one cycle");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !link_rst_req) // R8
    else $error("traffic while idle");

  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> attempt_cnt <= ATT_W'(RETRY_LIMIT + 1)) // R10
    else $error("attempt count above limit");
endmodule

bind lovr_sequencer lovr_checker #(
  .LANE_W(LANE_W), .RETRY_LIMIT(RETRY_LIMIT), .AW(AW), .DW(DW), .ATT_W($clog2(RETRY_LIMIT + 2))
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .busy(busy), .done(done), .link_rst_req(link_rst_req),
  .lane_active(lane_active), .attempt_cnt(attempt_cnt)
);

// File: tb/lovr_sequencer_tb.sv
module lovr_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANE_W  = 2;
  localparam int PLIM    = 6;
  localparam int SETTLE  = 20;
  localparam int RLIM    = 3;
  localparam int WD_LIM  = 150000;
  localparam int LOG_MAX = 512;

  logic clk = 0, rst_n = 0;
  logic phy_en = 1;
  logic [LANE_W-1:0] lane_sel = 0;
  logic [3:0] tx_atten = 0;
  logic ovr_start = 0, dis_start = 0, hrst_start = 0;
  logic link_rst_req, link_rst_done = 0, link_online = 0;
  logic [1:0] link_det = 0;
  logic req_valid, req_ready = 0, req_write;
  logic [15:0] req_addr, req_wdata;
  logic resp_valid = 0;
  logic [15:0] resp_rdata = 0;
  logic busy, done, timeout;

  always #(CLK_PERIOD/2) clk = ~clk;

  lovr_sequencer #(.LANE_W(LANE_W), .POLL_LIMIT(PLIM), .SETTLE_CYCLES(SETTLE), .RETRY_LIMIT(RLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .phy_en(phy_en), .lane_sel(lane_sel), .tx_atten(tx_atten),
    .ovr_start(ovr_start), .dis_start(dis_start), .hrst_start(hrst_start),
    .link_rst_req(link_rst_req), .link_rst_done(link_rst_done), .link_online(link_online),
    .link_det(link_det), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .busy(busy), .done(done), .timeout(timeout)
  );

  int checks = 0, errors = 0, cyc = 0;

  // PHY register model
  logic [15:0] rx_val [4];
  logic [15:0] tx_val [4];
  int half_left = 0;

  // observed traffic log
  logic        lg_wr [LOG_MAX];
  logic [15:0] lg_addr [LOG_MAX];
  logic [15:0] lg_data [LOG_MAX];
  int          lg_cyc [LOG_MAX];
  int          lg_n = 0;
  // expected traffic
  logic        ex_wr [LOG_MAX];
  logic [15:0] ex_addr [LOG_MAX];
  logic [15:0] ex_data [LOG_MAX];
  int          ex_n = 0;

  // link reset model
  logic sc_online [8];
  logic [1:0] sc_det [8];
  int lrst_n = 0, done_n = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIM) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < %0d", cyc, WD_LIM);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // register access responder
  logic p_valid = 0, p_write = 0;
  logic [15:0] p_addr = 0, p_wdata = 0;
  int rsp_cnt = -1;
  logic [15:0] rsp_val = 0;

  function automatic logic [15:0] model_read(input logic [15:0] a);
    int ln;
    logic [15:0] v;
    ln = int'(a[9:8]);
    if (a[7:0] == 8'h02) begin
      v = rx_val[ln];
      if (half_left > 0) begin v[0] = 1'b1; half_left--; end
    end else v = tx_val[ln];
    return v;
  endfunction

  always @(negedge clk) begin
    resp_valid <= 1'b0;
    if (rsp_cnt > 0) rsp_cnt--;
    if (rsp_cnt == 0) begin resp_valid <= 1'b1; resp_rdata <= rsp_val; rsp_cnt = -1; end
    if (p_valid && req_ready) begin
      lg_wr[lg_n] = p_write; lg_addr[lg_n] = p_addr; lg_cyc[lg_n] = cyc;
      if (p_write) lg_data[lg_n] = p_wdata;
      else begin
        rsp_val = model_read(p_addr); lg_data[lg_n] = rsp_val;
        rsp_cnt = 1 + int'($urandom % 3);
      end
      if (lg_n < LOG_MAX - 1) lg_n++;
    end
    p_valid = req_valid; p_write = req_write; p_addr = req_addr; p_wdata = req_wdata;
    req_ready <= ($urandom % 4) != 0;
    if (done) done_n++;
  end

  // link reset responder
  int lk_cnt = -1;
  always @(negedge clk) begin
    link_rst_done <= 1'b0;
    if (lk_cnt > 0) lk_cnt--;
    if (lk_cnt == 0) begin
      link_rst_done <= 1'b1;
      link_online <= sc_online[lrst_n - 1];
      link_det    <= sc_det[lrst_n - 1];
      lk_cnt = -1;
    end
    if (link_rst_req) begin lrst_n++; lk_cnt = 3; end
  end

  // ---------------- expected-value helpers ----------------
  function automatic logic [15:0] la(input int ofs, input int ln);
    return 16'(ofs + ln * 256);
  endfunction

  task automatic push(input logic w, input logic [15:0] a, input logic [15:0] d);
    ex_wr[ex_n] = w; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
  endtask

  // bench view of the override series; hp = number of half-rate reads queued
  task automatic exp_override(input int ln, input logic [3:0] att, input int hp, output logic gave);
    int polls;
    logic [15:0] b, t;
    polls = (hp >= PLIM) ? PLIM : hp + 1;
    gave  = (hp >= PLIM);
    for (int i = 0; i < polls; i++) push(0, la('h2002, ln), 0);
    push(0, la('h2002, ln), 0);
    b = rx_val[ln] | {15'd0, (polls < hp)};
    b = b & 16'hBFFF;            push(1, la('h2005, ln), b);
    b = b | 16'h4000;            push(1, la('h2005, ln), b);
    b = (b & 16'hF8FF) | 16'h0300; push(1, la('h2005, ln), b);
    b = b | 16'h0800;            push(1, la('h2005, ln), b);
    b = b & 16'hF7FF;            push(1, la('h2005, ln), b);
    if (!att[3]) begin
      push(0, la('h2001, ln), 0);
      t = tx_val[ln] & 16'h7FFF;  push(1, la('h2004, ln), t);
      t = t | 16'h8000;           push(1, la('h2004, ln), t);
      t = t | ({13'd0, att[2:0]} << 10); push(1, la('h2004, ln), t);
    end
  endtask

  task automatic exp_release(input int ln);
    push(0, la('h2002, ln), 0);
    push(1, la('h2005, ln), rx_val[ln] & 16'hBFFF);
  endtask

  task automatic clear_logs();
    lg_n = 0; ex_n = 0;
  endtask

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp_traffic(input string tag);
    int bad;
    bad = -1;
    if (lg_n == ex_n)
      for (int i = 0; i < ex_n; i++)
        if (bad < 0 && (lg_wr[i] != ex_wr[i] || lg_addr[i] != ex_addr[i] ||
                        (ex_wr[i] && lg_data[i] != ex_data[i]))) bad = i;
    if (lg_n != ex_n) chk({tag, " traffic count"}, 0, lg_n, ex_n);
    else if (bad >= 0)
      chk({tag, " traffic item"}, 0, {lg_wr[bad], lg_addr[bad], lg_data[bad]},
          {ex_wr[bad], ex_addr[bad], ex_data[bad]});
    else chk(tag, 1, 0, 0);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic run_override(input logic en, input int ln, input logic [3:0] att, input int hp);
    logic gave;
    clear_logs();
    phy_en = en; lane_sel = LANE_W'(ln); tx_atten = att; half_left = hp;
    gave = 0;
    if (en) exp_override(ln, att, hp, gave);
    pulse(ovr_start);
    if (!en) chk("R8 done one cycle after start with no PHY", done == 1'b1, done, 1);
    else wait_done();
    @(negedge clk);
    cmp_traffic(en ? "R2/R3/R4/R6 override series" : "R8 no traffic without PHY");
    chk("R3 half-rate give-up flag", timeout == gave, timeout, gave);
  endtask

  int lrst_base;

  task automatic run_hrst(input logic en, input int ln, input int exp_att, input logic exp_to, input string tag);
    logic gave;
    clear_logs();
    phy_en = en; lane_sel = LANE_W'(ln); tx_atten = 4'b0101; half_left = 0;
    lrst_n = 0;
    if (en) for (int a = 0; a < exp_att; a++) begin exp_release(ln); exp_override(ln, 4'b0101, 0, gave); end
    pulse(hrst_start);
    wait_done();
    @(negedge clk);
    chk({tag, " link reset count"}, lrst_n == exp_att, lrst_n, exp_att);
    cmp_traffic({tag, " R9 per-attempt order"});
    chk({tag, " timeout"}, timeout == exp_to, timeout, exp_to);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin
      rx_val[i] = 16'($urandom) & 16'hFFFE;
      tx_val[i] = 16'($urandom);
    end
    for (int i = 0; i < 8; i++) begin sc_online[i] = 0; sc_det[i] = 2'd3; end
    repeat (3) @(negedge clk);
    chk("R1 reset busy/done/timeout", {busy, done, timeout} == 3'b000, {busy, done, timeout}, 0);
    chk("R1 reset req_valid/link_rst_req", {req_valid, link_rst_req} == 2'b00, {req_valid, link_rst_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // directed: plain override lane 2, TX enabled
    run_override(1, 2, 4'b0110, 0);
    // directed: TX skipped (R6 bit 3)
    run_override(1, 1, 4'b1011, 0);
    // directed: half-rate clears on last allowed read (R3 boundary)
    run_override(1, 3, 4'b0001, PLIM - 1);
    // directed: half-rate never clears -> give up (R3)
    run_override(1, 0, 4'b0111, PLIM + 2);

    // settle gap (R5)
    begin
      int lastrx, txrd;
      run_override(1, 1, 4'b0010, 0);
      lastrx = -1; txrd = -1;
      for (int i = 0; i < lg_n; i++) begin
        if (lg_wr[i] && lg_addr[i][7:0] == 8'h05) lastrx = i;
        if (!lg_wr[i] && lg_addr[i][7:0] == 8'h01 && txrd < 0) txrd = i;
      end
      chk("R5 settle gap", lastrx >= 0 && txrd > lastrx && lg_cyc[txrd] - lg_cyc[lastrx] >= SETTLE,
          (txrd > 0 && lastrx >= 0) ? lg_cyc[txrd] - lg_cyc[lastrx] : -1, SETTLE);
    end

    // release (R7)
    clear_logs(); phy_en = 1; lane_sel = 2'd3; exp_release(3);
    pulse(dis_start); wait_done(); @(negedge clk);
    cmp_traffic("R7 release series");

    // no PHY (R8)
    run_override(0, 2, 4'b0000, 0);
    clear_logs(); phy_en = 0;
    pulse(dis_start);
    chk("R8 release done at once without PHY", done == 1'b1, done, 1);
    @(negedge clk);
    cmp_traffic("R8 release no traffic");

    // busy ignore (R13)
    begin
      logic gave;
      clear_logs(); phy_en = 1; lane_sel = 2'd0; tx_atten = 4'b0011; half_left = 0; lrst_n = 0;
      exp_override(0, 4'b0011, 0, gave);
      pulse(ovr_start);
      repeat (3) @(negedge clk);
      pulse(dis_start);
      pulse(hrst_start);
      done_n = 0;
      wait_done(); repeat (4) @(negedge clk);
      cmp_traffic("R13 starts while busy ignored");
      chk("R13 no link reset from ignored start", lrst_n == 0, lrst_n, 0);
      chk("R13 single done pulse", done_n == 1, done_n, 1);
    end

    // hard reset scenarios
    sc_online[1] = 1;
    run_hrst(1, 1, 2, 0, "R10 online on second attempt");
    sc_online[1] = 0;
    run_hrst(1, 2, RLIM + 1, 1, "R10 retry limit exhausted");
    sc_det[0] = 2'd0;
    run_hrst(1, 0, 1, 0, "R11 zero detect stops early");
    sc_det[0] = 2'd1;
    run_hrst(0, 3, RLIM + 1, 1, "R8 hard reset without PHY");

    // constrained random overrides
    for (int k = 0; k < 14; k++) begin
      run_override(($urandom % 6) != 0, int'($urandom % 4), 4'($urandom), int'($urandom % (PLIM + 3)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule